// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag

This block is the arithmetic and logic datapath of an 8-bit accumulator machine. Each cycle it takes the current accumulator, a memory operand, the incoming carry flag and a 4-bit operation code. It produces the next accumulator value and the next carry flag. The operations are a memory load, three bitwise combinations, two additions, four subtractions and four shifts. For subtraction the carry flag holds the inverse of the borrow. The borrowing forms feed that flag back in as the low-order term. Each subtraction can be done with the memory operand first or with the accumulator first.

The result logic is purely combinational. The parameter `REG_OUT` (default 1) selects whether the result passes through a clock-enabled output register or goes straight to the ports. The surrounding sequencer fetches operands and writes the result back. This block does not decode instructions.

Top module: `acc_alu`

## Requirements
- R1: Code 0 loads the memory operand. Code 1 gives OR, code 2 gives AND and code 3 gives XOR of the memory operand and the accumulator. All four leave the carry flag equal to `cy_in`.
- R2: Code 4 (add) forms the 9-bit sum of accumulator and memory operand. The result takes bits 7..0 and the carry flag takes bit 8. `cy_in` is ignored.
- R3: Code 5 (add with carry) adds `cy_in` as a third term, with the same split of the result.
- R4: Code 6 computes memory minus accumulator and code 7 computes accumulator minus memory. Both add the one's complement of the subtrahend plus one. The carry flag is 1 exactly when no borrow occurs (minuend >= subtrahend).
- R5: Code 8 (memory first) and code 9 (accumulator first) subtract with borrow. They add `cy_in` in place of the constant one.
- R6: Code 10 shifts right and code 11 shifts left, with zero fill. The bit shifted out goes to the carry flag.
- R7: Code 12 rotates right through carry: old carry into bit 7, bit 0 into carry. Code 13 rotates left through carry: old carry into bit 0, bit 7 into carry. The stored carry is always a single bit 0 or 1.
- R8: Codes 14 and 15 pass the accumulator and carry through unchanged.
- R9: With `REG_OUT`=1, the outputs show the result of the inputs present at a rising edge where `en` is 1. They hold their value across edges where `en` is 0.
- R10: While reset is active the outputs are 0. Reset is asserted asynchronously and released synchronously, two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output register clock enable |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Current accumulator value |
| mem_in | input | 8 | Memory operand |
| cy_in | input | 1 | Current carry flag |
| acc_out | output | 8 | New accumulator value |
| cy_out | output | 1 | New carry flag |

## Verification
The assertions assume that `op`, `acc_in`, `mem_in` and `cy_in` are stable and known at every rising edge after reset release. The combinational checks and the register-capture checks rely on that. The bench changes inputs only on falling edges and holds them through the following rising edge. It only starts applying operations after the synchronized reset has been released.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_LDM  = 4'd0,
    OP_OR   = 4'd1,
    OP_AND  = 4'd2,
    OP_XOR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_ADC  = 4'd5,
    OP_SUBM = 4'd6,
    OP_SUBA = 4'd7,
    OP_SBBM = 4'd8,
    OP_SBBA = 4'd9,
    OP_SHR  = 4'd10,
    OP_SHL  = 4'd11,
    OP_ROR  = 4'd12,
    OP_ROL  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int W = 8
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mem,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = mem;
      2'd1:    y = mem | acc;
      2'd2:    y = mem & acc;
      default: y = mem ^ acc;
    endcase
  end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         inv,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int SW = W + 1;
  logic [W-1:0]  rhs_eff;
  logic [SW-1:0] total;

  always_comb begin
    rhs_eff = inv ? ~rhs : rhs;
    total   = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, cin};
    sum     = total[W-1:0];
    cout    = total[W];
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic         cy,
  input  logic         left,
  input  logic         ring,
  output logic [W-1:0] y,
  output logic         cout
);
  logic fill;

  always_comb begin
    fill = ring & cy;
    if (left) begin
      y    = {acc[W-2:0], fill};
      cout = acc[W-1];
    end else begin
      y    = {fill, acc[W-1:1]};
      cout = acc[0];
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] mem_in,
  input  logic         cy_in,
  output logic [W-1:0] acc_out,
  output logic         cy_out
);
  localparam int SYNC_STAGES = 2;

  alu_op_e      op_e;
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic         rst_sync;
  logic [W-1:0] lg_y, ar_sum, sh_y, ar_lhs, ar_rhs;
  logic         ar_inv, ar_cin, ar_cout, sh_cout;
  logic [W-1:0] nxt_acc;
  logic         nxt_cy;

  assign op_e = alu_op_e'(op);

  // reset: asserted asynchronously, released after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync = rst_pipe[SYNC_STAGES-1];

  // arithmetic operand steering
  always_comb begin
    ar_lhs = acc_in;
    ar_rhs = mem_in;
    ar_inv = 1'b0;
    ar_cin = 1'b0;
    unique case (op_e)
      OP_ADC:  ar_cin = cy_in;
      OP_SUBM: begin ar_lhs = mem_in; ar_rhs = acc_in; ar_inv = 1'b1; ar_cin = 1'b1;  end
      OP_SUBA: begin ar_inv = 1'b1; ar_cin = 1'b1;  end
      OP_SBBM: begin ar_lhs = mem_in; ar_rhs = acc_in; ar_inv = 1'b1; ar_cin = cy_in; end
      OP_SBBA: begin ar_inv = 1'b1; ar_cin = cy_in; end
      default: ;
    endcase
  end

  acc_alu_logic #(.W(W)) u_logic (
    .sel(op[1:0]), .acc(acc_in), .mem(mem_in), .y(lg_y)
  );

  acc_alu_arith #(.W(W)) u_arith (
    .lhs(ar_lhs), .rhs(ar_rhs), .inv(ar_inv), .cin(ar_cin),
    .sum(ar_sum), .cout(ar_cout)
  );

  acc_alu_shift #(.W(W)) u_shift (
    .acc(acc_in), .cy(cy_in), .left(op[0]), .ring(op[3] & op[2]),
    .y(sh_y), .cout(sh_cout)
  );

  // result select
  always_comb begin
    nxt_acc = acc_in;
    nxt_cy  = cy_in;
    unique case (op_e)
      OP_LDM, OP_OR, OP_AND, OP_XOR: nxt_acc = lg_y;
      OP_ADD, OP_ADC, OP_SUBM, OP_SUBA, OP_SBBM, OP_SBBA: begin
        nxt_acc = ar_sum;
        nxt_cy  = ar_cout;
      end
      OP_SHR, OP_SHL, OP_ROR, OP_ROL: begin
        nxt_acc = sh_y;
        nxt_cy  = sh_cout;
      end
      default: ;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] acc_q;
      logic         cy_q;
      always_ff @(posedge clk or negedge rst_sync) begin
        if (!rst_sync) begin
          acc_q <= '0;
          cy_q  <= 1'b0;
        end else if (en) begin
          acc_q <= nxt_acc;
          cy_q  <= nxt_cy;
        end
      end
      assign acc_out = acc_q;
      assign cy_out  = cy_q;

      // R9
      reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync)
        en |=> (acc_out == $past(nxt_acc)) && (cy_out == $past(nxt_cy)));
      // R9
      reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
        !en |=> $stable(acc_out) && $stable(cy_out));
      // R10
      reset_zero_chk: assert property (@(posedge clk)
        !rst_sync |-> (acc_out == '0) && !cy_out);
    end else begin : g_comb
      assign acc_out = nxt_acc;
      assign cy_out  = nxt_cy;
    end
  endgenerate

  // R1
  logic_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (op < 4'd4) |-> (nxt_cy == cy_in));
  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (op == 4'd4) |-> ({nxt_cy, nxt_acc} == ({1'b0, acc_in} + {1'b0, mem_in})));
  // R4
  sub_noborrow_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (op == 4'd7) |-> (nxt_cy == (acc_in >= mem_in)) && (nxt_acc == W'(acc_in - mem_in)));
  // R6
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (op == 4'd10) |-> !nxt_acc[W-1] && (nxt_cy == acc_in[0]));
  // R7
  rol_carry_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (op == 4'd13) |-> (nxt_acc[0] == cy_in) && (nxt_cy == acc_in[W-1]));
  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (op >= 4'd14) |-> (nxt_acc == acc_in) && (nxt_cy == cy_in));
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [3:0] op;
  logic [7:0] acc_in, mem_in;
  logic       cy_in;
  logic [7:0] acc_out;
  logic       cy_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc_in(acc_in),
    .mem_in(mem_in), .cy_in(cy_in), .acc_out(acc_out), .cy_out(cy_out)
  );

  // {op, acc, mem, cy, expected acc, expected cy}
  localparam int NV = 26;
  localparam logic [29:0] VEC [NV] = '{
    {4'h0, 8'h12, 8'h5A, 1'b1, 8'h5A, 1'b1},  // R1 load
    {4'h1, 8'hF0, 8'h0F, 1'b0, 8'hFF, 1'b0},  // R1 or
    {4'h2, 8'h3C, 8'h0F, 1'b1, 8'h0C, 1'b1},  // R1 and
    {4'h3, 8'hAA, 8'hFF, 1'b0, 8'h55, 1'b0},  // R1 xor
    {4'h4, 8'h80, 8'h80, 1'b1, 8'h00, 1'b1},  // R2 carry out
    {4'h4, 8'h12, 8'h34, 1'b1, 8'h46, 1'b0},  // R2 cy_in ignored
    {4'h5, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1},  // R3
    {4'h5, 8'h10, 8'h20, 1'b0, 8'h30, 1'b0},  // R3
    {4'h6, 8'h05, 8'h10, 1'b0, 8'h0B, 1'b1},  // R4 mem-acc
    {4'h6, 8'h10, 8'h05, 1'b1, 8'hF5, 1'b0},  // R4 borrow
    {4'h7, 8'h05, 8'h10, 1'b1, 8'hF5, 1'b0},  // R4 acc-mem
    {4'h7, 8'h33, 8'h33, 1'b0, 8'h00, 1'b1},  // R4 equal
    {4'h8, 8'h05, 8'h10, 1'b0, 8'h0A, 1'b1},  // R5
    {4'h8, 8'h05, 8'h10, 1'b1, 8'h0B, 1'b1},  // R5
    {4'h9, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0},  // R5
    {4'h9, 8'h50, 8'h20, 1'b1, 8'h30, 1'b1},  // R5
    {4'hA, 8'h81, 8'h00, 1'b0, 8'h40, 1'b1},  // R6 shr
    {4'hA, 8'h02, 8'h00, 1'b1, 8'h01, 1'b0},  // R6 shr zero fill
    {4'hB, 8'h81, 8'h00, 1'b0, 8'h02, 1'b1},  // R6 shl
    {4'hB, 8'h01, 8'h00, 1'b1, 8'h02, 1'b0},  // R6 shl zero fill
    {4'hC, 8'h01, 8'h00, 1'b1, 8'h80, 1'b1},  // R7 ror
    {4'hC, 8'h02, 8'h00, 1'b0, 8'h01, 1'b0},  // R7 ror
    {4'hD, 8'h80, 8'h00, 1'b1, 8'h01, 1'b1},  // R7 rol
    {4'hD, 8'h40, 8'h00, 1'b0, 8'h80, 1'b0},  // R7 rol
    {4'hE, 8'h5A, 8'h33, 1'b1, 8'h5A, 1'b1},  // R8
    {4'hF, 8'hA5, 8'hCC, 1'b0, 8'hA5, 1'b0}   // R8
  };

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got cy=%0b acc=%02h, expected cy=%0b acc=%02h",
               req, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    if (o < 4)       return "R1";
    else if (o == 4) return "R2";
    else if (o == 5) return "R3";
    else if (o < 8)  return "R4";
    else if (o < 10) return "R5";
    else if (o < 12) return "R6";
    else if (o < 14) return "R7";
    else             return "R8";
  endfunction

  function automatic logic [8:0] model(input logic [3:0] o, input logic [7:0] a,
                                       input logic [7:0] m, input logic c);
    logic [8:0] r;
    case (o)
      4'd0: r = {c, m};
      4'd1: r = {c, m | a};
      4'd2: r = {c, m & a};
      4'd3: r = {c, m ^ a};
      4'd4: r = {1'b0, a} + {1'b0, m};
      4'd5: r = {1'b0, a} + {1'b0, m} + {8'd0, c};
      4'd6: r = {(m >= a), 8'(m - a)};
      4'd7: r = {(a >= m), 8'(a - m)};
      4'd8: r = {({1'b0, m} >= ({1'b0, a} + {8'd0, !c})), 8'(m - a - {7'd0, !c})};
      4'd9: r = {({1'b0, a} >= ({1'b0, m} + {8'd0, !c})), 8'(a - m - {7'd0, !c})};
      4'd10: r = {a[0], 1'b0, a[7:1]};
      4'd11: r = {a[7], a[6:0], 1'b0};
      4'd12: r = {a[0], c, a[7:1]};
      4'd13: r = {a[7], a[6:0], c};
      default: r = {c, a};
    endcase
    return r;
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] a,
                       input logic [7:0] m, input logic c);
    @(negedge clk);
    op = o; acc_in = a; mem_in = m; cy_in = c; en = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] held;
    rst_n = 1'b0; en = 1'b1; op = 4'h3; acc_in = 8'hFF; mem_in = 8'h0F; cy_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset state", {cy_out, acc_out}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 synchronized release, still zero", {cy_out, acc_out}, 9'h000);
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][29:26], VEC[i][25:18], VEC[i][17:10], VEC[i][9]);
      chk(req_of(VEC[i][29:26]), {cy_out, acc_out}, {VEC[i][0], VEC[i][8:1]});
    end

    for (int i = 0; i < 256; i++) begin
      logic [3:0] o;
      logic [7:0] a, m;
      logic       c;
      o = 4'(i);
      a = 8'(i * 37 + 11);
      m = 8'(i * 91 + 5);
      c = i[4] ^ i[6];
      apply(o, a, m, c);
      chk(req_of(o), {cy_out, acc_out}, model(o, a, m, c));
    end

    // R9: enable low holds the previous result
    apply(4'h4, 8'h01, 8'h02, 1'b0);
    held = {cy_out, acc_out};
    chk("R9 capture", held, 9'h003);
    @(negedge clk);
    en = 1'b0; op = 4'h3; acc_in = 8'hFF; mem_in = 8'h00; cy_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 hold with en low", {cy_out, acc_out}, held);
    en = 1'b1;
    @(negedge clk);
    chk("R9 resume", {cy_out, acc_out}, 9'h1FF);

    // R7: rotate left with carry set stores a single bit in bit 0
    apply(4'hD, 8'h00, 8'h00, 1'b1);
    chk("R7 rol carry bit", {cy_out, acc_out}, 9'h001);

    // R10: asynchronous reset mid-run
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk("R10 async clear", {cy_out, acc_out}, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(4'h0, 8'h00, 8'h77, 1'b0);
    chk("R1 after reset", {cy_out, acc_out}, 9'h077);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule